// File: doc/BRIEF.md
# Static LCD Segment and Backplane Driver

This block drives a static, non-multiplexed liquid-crystal readout of three full decimal digits, a leading half digit that can only show "1", and a minus sign. It divides the system clock down to a square-wave backplane. Every segment pin then carries the same square wave, either in phase with the backplane (segment dark) or inverted (segment visible). Because each segment only ever differs from the backplane by a phase choice at equal frequency and amplitude, no net DC appears across any segment.

The decimal digits arrive as packed BCD codes and are decoded here to seven segments each. Codes above nine blank their digit. A lamp-test input lights every segment, so the glass reads "-1888". The segments keep their square-wave drive in that mode, so lamp test causes no DC stress. All inputs are plain levels sampled on every clock; there is no stream interface and no back-pressure. The segment register and the backplane register update on the same edge, so the two never drift apart.

Top module: `lcd_static_drive`

## Requirements
- R1: While `rst_n` is low, `bp_out` is 0 and every bit of `seg_out` is 0.
- R2: After reset is released, `bp_out` inverts on every DIV/2-th rising clock edge (400 with the default DIV=800), giving a 50% duty square wave of period DIV clocks; it is first 1 after the 400th edge.
- R3: Each `seg_out` bit equals `bp_out` when its segment is off and `~bp_out` when it is on, where on/off comes from the inputs sampled at the same edge that last updated the outputs.
- R4: Digit i (i=0 is the ones digit) uses `bcd_in[4i+3:4i]` and drives `seg_out[7i+6:7i]` with segment a at bit 7i through g at bit 7i+6; codes 0..9 light the usual patterns (gfedcba): 3F,06,5B,4F,66,6D,7D,07,7F,6F.
- R5: A digit code of 10 to 15 lights none of that digit's seven segments.
- R6: The half digit's b and c segments are `seg_out[21]` and `seg_out[22]`; both are on exactly when `half_on` is 1.
- R7: The minus segment `seg_out[23]` is on exactly when `minus_on` is 1.
- R8: When `lamp_on` is 1, all 24 segments are on (still inverted against `bp_out`), whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_in | input | 12 | Three BCD digits, ones in bits 3:0 |
| half_on | input | 1 | Show the leading "1" |
| minus_on | input | 1 | Show the minus sign |
| lamp_on | input | 1 | Light every segment |
| bp_out | output | 1 | Backplane square wave |
| seg_out | output | 24 | Segment drives, layout per R4, R6, R7 |

## Verification
A fault in the divider shows at `bp_out` within one half period: a wrong terminal count moves the first rising edge away from edge 400. A fault in the decode or override path shows at `seg_out` on the first edge after the offending input pattern. There the bit disagrees with `bp_out` XOR its expected on-state, so every mismatch is visible one clock after the stimulus. The segment XOR is relative to `bp_out`, so a phase slip between segment and backplane registers appears on every toggle edge.

// File: rtl/lcd_drive_pkg.sv
package lcd_drive_pkg;
  localparam int SEGS_PER_DIGIT = 7;
  localparam int EXTRA_SEGS     = 3;  // half-digit b, half-digit c, minus

  typedef logic [SEGS_PER_DIGIT-1:0] seven_t;

  function automatic seven_t bcd_to_seven(input logic [3:0] code);
    seven_t s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int DIV = 800
) (
  input  logic clk,
  input  logic rst_n,
  output logic bp_q,
  output logic bp_next
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          flip;

  assign flip    = (cnt == LAST);
  assign bp_next = bp_q ^ flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bp_q <= 1'b0;
    end else begin
      cnt  <= flip ? '0 : cnt + 1'b1;
      bp_q <= bp_next;
    end
  end
endmodule

// File: rtl/lcd_digit_dec.sv
module lcd_digit_dec
  import lcd_drive_pkg::*;
(
  input  logic [3:0] code,
  output seven_t     segs
);
  assign segs = bcd_to_seven(code);
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
  import lcd_drive_pkg::*;
#(
  parameter int NDIG = 3
) (
  input  logic [4*NDIG-1:0] bcd_in,
  input  logic              half_on,
  input  logic              minus_on,
  input  logic              lamp_on,
  output logic [NDIG*SEGS_PER_DIGIT+EXTRA_SEGS-1:0] on_bits
);
  localparam int DSEG = NDIG * SEGS_PER_DIGIT;
  localparam int NSEG = DSEG + EXTRA_SEGS;

  logic [NSEG-1:0] raw;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    lcd_digit_dec u_dec (
      .code (bcd_in[4*i +: 4]),
      .segs (raw[SEGS_PER_DIGIT*i +: SEGS_PER_DIGIT])
    );
  end

  assign raw[DSEG]     = half_on;
  assign raw[DSEG + 1] = half_on;
  assign raw[DSEG + 2] = minus_on;

  assign on_bits = lamp_on ? {NSEG{1'b1}} : raw;
endmodule

// File: rtl/lcd_static_drive.sv
module lcd_static_drive
  import lcd_drive_pkg::*;
#(
  parameter int DIV  = 800,
  parameter int NDIG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4*NDIG-1:0]   bcd_in,
  input  logic                half_on,
  input  logic                minus_on,
  input  logic                lamp_on,
  output logic                bp_out,
  output logic [NDIG*SEGS_PER_DIGIT+EXTRA_SEGS-1:0] seg_out
);
  localparam int NSEG = NDIG * SEGS_PER_DIGIT + EXTRA_SEGS;

  logic            bp_next;
  logic [NSEG-1:0] on_bits;
  logic [NSEG-1:0] seg_q;

  lcd_bp_divider #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .bp_q    (bp_out),
    .bp_next (bp_next)
  );

  lcd_seg_map #(.NDIG(NDIG)) u_map (
    .bcd_in   (bcd_in),
    .half_on  (half_on),
    .minus_on (minus_on),
    .lamp_on  (lamp_on),
    .on_bits  (on_bits)
  );

  // Same edge as the backplane register: segment = next backplane ^ on-bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else        seg_q <= on_bits ^ {NSEG{bp_next}};
  end

  assign seg_out = seg_q;
endmodule

// File: rtl/lcd_static_drive_chk.sv
module lcd_static_drive_chk #(
  parameter int DIV  = 800,
  parameter int NDIG = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [4*NDIG-1:0]   bcd_in,
  input logic                half_on,
  input logic                minus_on,
  input logic                lamp_on,
  input logic                bp_out,
  input logic [NDIG*7+2:0]   seg_out
);
  localparam int NSEG = NDIG * 7 + 3;
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] mon_cnt;
  logic          live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_cnt <= '0;
      live    <= 1'b0;
    end else begin
      live    <= 1'b1;
      mon_cnt <= (mon_cnt == CW'(HALF - 1)) ? '0 : mon_cnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (bp_out == 1'b0 && seg_out == '0));

  // R2
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_cnt != CW'(HALF - 1)) |=> $stable(bp_out));

  // R2
  bp_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_cnt == CW'(HALF - 1)) |=> (bp_out != $past(bp_out)));

  // R8
  lamp_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && lamp_on) |=> (seg_out == {NSEG{~bp_out}}));

  // R7
  minus_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !lamp_on) |=> (seg_out[NSEG-1] == (bp_out ^ $past(minus_on))));

  // R6
  half_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !lamp_on) |=> (seg_out[NSEG-2:NSEG-3] == {2{bp_out ^ $past(half_on)}}));

  // R5
  blank_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !lamp_on && bcd_in[3:0] > 4'd9) |=> (seg_out[6:0] == {7{bp_out}}));
endmodule

bind lcd_static_drive lcd_static_drive_chk #(.DIV(DIV), .NDIG(NDIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .half_on(half_on),
  .minus_on(minus_on), .lamp_on(lamp_on), .bp_out(bp_out), .seg_out(seg_out)
);

// File: tb/test_lcd_static_drive.sv
`timescale 1ns/1ps
module test_lcd_static_drive;
  localparam int DIV = 800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bcd_in = '0;
  logic        half_on = 1'b0, minus_on = 1'b0, lamp_on = 1'b0;
  logic        bp_out;
  logic [23:0] seg_out;

  int errors = 0, checks = 0, edges = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_static_drive i_lcd_static_drive (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .half_on(half_on),
    .minus_on(minus_on), .lamp_on(lamp_on), .bp_out(bp_out), .seg_out(seg_out)
  );

  always @(posedge clk) if (rst_n) edges++;

  function automatic logic [6:0] ref_seven(input logic [3:0] c);
    logic [9:0][6:0] tbl = '{7'h6F,7'h7F,7'h07,7'h7D,7'h6D,7'h66,7'h4F,7'h5B,7'h06,7'h3F};
    return (c <= 4'd9) ? tbl[c] : 7'h00;
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Checks outputs against inputs held since the previous negedge.
  task automatic check_all();
    logic bpx;
    logic [23:0] ph;
    bpx = ((edges / (DIV/2)) % 2) != 0;
    check("R2 backplane", {23'd0, bp_out}, {23'd0, bpx});
    ph = {24{bp_out}};
    if (lamp_on) begin
      check("R8 lamp", seg_out, ~ph);
    end else begin
      for (int i = 0; i < 3; i++) begin
        logic [3:0] c = bcd_in[4*i +: 4];
        check(c > 9 ? "R5 blank digit" : "R4 digit decode",
              {17'd0, seg_out[7*i +: 7]}, {17'd0, ref_seven(c) ^ ph[6:0]});
      end
      check("R6 half digit", {22'd0, seg_out[22:21]}, {22'd0, {2{half_on}} ^ ph[1:0]});
      check("R7 minus", {23'd0, seg_out[23]}, {23'd0, minus_on ^ bp_out});
    end
  endtask

  task automatic step(input logic [11:0] b, input logic h, input logic m, input logic l);
    @(negedge clk);
    check_all();
    bcd_in = b; half_on = h; minus_on = m; lamp_on = l;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset bp", {23'd0, bp_out}, 24'd0);
    check("R1 reset seg", seg_out, 24'd0);
    rst_n = 1'b1;
    // directed corners
    step(12'h888, 1, 1, 0);
    step(12'h888, 1, 1, 0);
    step(12'hFAB, 0, 0, 0);   // R5 all blank
    step(12'h123, 0, 1, 1);   // R8 lamp
    step(12'h456, 1, 0, 0);
    step(12'h790, 0, 0, 0);
    // R3 phase across many backplane toggles, random patterns
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      step(12'($urandom()), 1'($urandom()), 1'($urandom()), r == 0);
    end
    step(12'h000, 0, 0, 0);
    @(negedge clk);
    check_all();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule